// File: doc/BRIEF.md
# Countdown Interval Timer

This block is a down-counting interval timer behind a small word-addressed register interface. Software loads a period value, which also goes straight into the live counter, and then starts or stops counting with two strobe bits inside the stored control word. While the timer runs, the counter drops by one on every clock. When it expires, a sticky timeout flag is set. In one-shot mode the counter then halts. In continuous mode it reloads from the period register and keeps running.

A single level-sensitive interrupt line is high whenever the timeout flag is set and the control word enables the interrupt. Any write to the status word clears the flag, whatever data it carries. A read-only snapshot word returns the live count. Register reads are combinational from the address. Writes take effect at the clock edge where the write enable is sampled high.

Top module: `interval_timer`

## Requirements
- R1: After reset, the status, control, period and snapshot words all read 0 and `irq` is low.
- R2: The register is selected by byte address bits [ADDR_W-1:2]: word 0 is status, word 1 is control, word 2 is period, word 3 is snapshot. Address bits [1:0] are ignored.
- R3: A write to the period word stores the data. The same edge loads it into the counter, so the snapshot word returns it on the next cycle.
- R4: A write to the control word stores the full data word, which reads back unchanged. Bit 2 set starts counting and bit 3 set stops it. If both are set in one write, stop takes priority.
- R5: While running, the counter decrements by one per clock, except on an edge where it is loaded or reloaded. The snapshot word returns the live count.
- R6: A running counter that holds 1 or 0 expires at the next edge, which sets status bit 0 (timeout). With control bit 1 clear (one-shot), the counter becomes 0 and status bit 1 (running) clears.
- R7: With control bit 1 set (continuous), expiry reloads the counter from the period word and status bit 1 stays set.
- R8: Any write to the status word clears status bit 0, regardless of the data. If an expiry happens on the same edge, the flag is set instead.
- R9: `irq` is high exactly when status bit 0 and control bit 0 are both set.
- R10: Writes to the snapshot word and to word indices 4 and above change nothing. Reads of word indices 4 and above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the word |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the addressed word (combinational) |
| irq | output | 1 | Level interrupt: timeout AND interrupt enable |

## Verification
The hardest situations to reach are register writes that land on the same edge as an expiry. Examples are a status clear that meets a new timeout, a stop or start strobe on the expiring edge, and a period write that overrides a continuous reload. The random stimulus keeps periods between 0 and 11, so expiries come every few cycles and collide often with the frequent writes. A directed sequence also times a status write to fall exactly on an expiry edge. A bench model updated each cycle predicts every read and the interrupt level, so each collision is checked as it occurs.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;
   // word indices (after dropping the two byte-lane bits)
   localparam int unsigned WIDX_STATUS = 0;
   localparam int unsigned WIDX_CTRL   = 1;
   localparam int unsigned WIDX_PERIOD = 2;
   localparam int unsigned WIDX_SNAP   = 3;

   // control word bit positions
   localparam int unsigned CB_IEN  = 0;
   localparam int unsigned CB_CONT = 1;
   localparam int unsigned CB_GO   = 2;
   localparam int unsigned CB_HALT = 3;

   // status word bit positions
   localparam int unsigned SB_TMO = 0;
   localparam int unsigned SB_RUN = 1;

   typedef struct packed {
      logic status;
      logic ctrl;
      logic period;
   } itmr_wstb_t;
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
   import interval_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] status_word,
   input  logic [DATA_W-1:0] ctrl_word,
   input  logic [DATA_W-1:0] period_word,
   input  logic [DATA_W-1:0] count_word,
   output itmr_wstb_t        wstb,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             low_hit;
   logic [1:0]       sel;

   assign idx = addr[ADDR_W-1:2];
   assign sel = idx[1:0];

   generate
      if (IDX_W > 2) begin : g_wide_map
         assign low_hit = (idx[IDX_W-1:2] == '0);
      end else begin : g_exact_map
         assign low_hit = 1'b1;
      end
   endgenerate

   always_comb begin
      wstb        = '0;
      wstb.status = wr_en && low_hit && (sel == 2'(WIDX_STATUS));
      wstb.ctrl   = wr_en && low_hit && (sel == 2'(WIDX_CTRL));
      wstb.period = wr_en && low_hit && (sel == 2'(WIDX_PERIOD));
   end

   always_comb begin
      rdata = '0;
      if (low_hit) begin
         unique case (sel)
            2'(WIDX_STATUS): rdata = status_word;
            2'(WIDX_CTRL):   rdata = ctrl_word;
            2'(WIDX_PERIOD): rdata = period_word;
            default:         rdata = count_word;
         endcase
      end
   end
endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
   import interval_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  itmr_wstb_t        wstb,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] period_q,
   output logic              tmo_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '0;
         tmo_q    <= 1'b0;
      end else begin
         if (wstb.ctrl)   ctrl_q   <= wdata;
         if (wstb.period) period_q <= wdata;
         if (expire)           tmo_q <= 1'b1;
         else if (wstb.status) tmo_q <= 1'b0;
      end
   end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
   import interval_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  itmr_wstb_t        wstb,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] period_q,
   input  logic              cont,
   output logic [DATA_W-1:0] cnt_q,
   output logic              run_q,
   output logic              expire
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic go, halt;

   assign go     = wstb.ctrl && wdata[CB_GO];
   assign halt   = wstb.ctrl && wdata[CB_HALT];
   assign expire = run_q && (cnt_q <= ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else begin
         if (wstb.period)  cnt_q <= wdata;
         else if (expire)  cnt_q <= cont ? period_q : '0;
         else if (run_q)   cnt_q <= cnt_q - ONE;

         if (halt)                 run_q <= 1'b0;
         else if (go)              run_q <= 1'b1;
         else if (expire && !cont) run_q <= 1'b0;
      end
   end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
   import interval_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   generate
      if (DATA_W < 4) begin : g_bad_data_w
         $error("interval_timer: DATA_W must be at least 4");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("interval_timer: ADDR_W must be at least 4");
      end
   endgenerate

   itmr_wstb_t        wstb;
   logic [DATA_W-1:0] ctrl_q, period_q, cnt_q, status_w;
   logic              tmo_q, run_q, expire;

   assign status_w = DATA_W'({run_q, tmo_q});
   assign irq      = tmo_q && ctrl_q[CB_IEN];

   itmr_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
      .wr_en       (wr_en),
      .addr        (addr),
      .status_word (status_w),
      .ctrl_word   (ctrl_q),
      .period_word (period_q),
      .count_word  (cnt_q),
      .wstb        (wstb),
      .rdata       (rdata)
   );

   itmr_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wstb     (wstb),
      .wdata    (wdata),
      .expire   (expire),
      .ctrl_q   (ctrl_q),
      .period_q (period_q),
      .tmo_q    (tmo_q)
   );

   itmr_counter #(.DATA_W(DATA_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .wstb     (wstb),
      .wdata    (wdata),
      .period_q (period_q),
      .cont     (ctrl_q[CB_CONT]),
      .cnt_q    (cnt_q),
      .run_q    (run_q),
      .expire   (expire)
   );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [DATA_W-1:0] cnt_q,
   input logic [DATA_W-1:0] ctrl_q,
   input logic              run_q,
   input logic              tmo_q
);
   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [IDX_W-1:0] idx;
   logic wr_s, wr_c, wr_p, ending;
   assign idx    = addr[ADDR_W-1:2];
   assign wr_s   = wr_en && (idx == IDX_W'(0));
   assign wr_c   = wr_en && (idx == IDX_W'(1));
   assign wr_p   = wr_en && (idx == IDX_W'(2));
   assign ending = run_q && (cnt_q <= ONE);

   // R3
   period_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_p |=> cnt_q == $past(wdata));

   // R4
   halt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c && wdata[3]) |=> !run_q);

   // R4
   go_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c && wdata[2] && !wdata[3]) |=> run_q);

   // R5
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt_q > ONE && !wr_p) |=> cnt_q == $past(cnt_q) - ONE);

   // R6
   oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ending && !ctrl_q[1] && !wr_c && !wr_p) |=> (!run_q && tmo_q && cnt_q == '0));

   // R7
   cont_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ending && ctrl_q[1] && !wr_c) |=> (run_q && tmo_q));

   // R8
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_s && !ending) |=> !tmo_q);

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx >= IDX_W'(4)) |-> rdata == '0);
endmodule

bind interval_timer interval_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .cnt_q  (cnt_q),
   .ctrl_q (ctrl_q),
   .run_q  (run_q),
   .tmo_q  (tmo_q)
);

// File: tb/test_interval_timer.sv
module test_interval_timer;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int n_run = 0;
   int n_bad = 0;
   bit done = 0;

   // bench model state
   logic          m_tmo, m_run;
   logic [DW-1:0] m_ctrl, m_per, m_cnt;

   always #2 clk = ~clk;

   interval_timer #(.DATA_W(DW), .ADDR_W(AW)) i_interval_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
      case (a[AW-1:2])
         3'd0:    return DW'({m_run, m_tmo});
         3'd1:    return m_ctrl;
         3'd2:    return m_per;
         3'd3:    return m_cnt;
         default: return '0;
      endcase
   endfunction

   function automatic string tag_of(input logic [AW-1:0] a);
      case (a[AW-1:2])
         3'd0:    return "R6/R8";
         3'd1:    return "R4";
         3'd2:    return "R3";
         3'd3:    return "R5";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      m_tmo = 0; m_run = 0; m_ctrl = '0; m_per = '0; m_cnt = '0;
   endtask

   task automatic model_edge(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic ex, ws, wc, wp;
      logic [DW-1:0] n_cnt;
      logic n_run_v, n_tmo;
      ex = m_run && (m_cnt <= 1);
      ws = we && a[AW-1:2] == 3'd0;
      wc = we && a[AW-1:2] == 3'd1;
      wp = we && a[AW-1:2] == 3'd2;
      n_cnt   = wp ? d : ex ? (m_ctrl[1] ? m_per : '0) : m_run ? m_cnt - 1 : m_cnt;
      n_run_v = (wc && d[3]) ? 1'b0 : (wc && d[2]) ? 1'b1 : (ex && !m_ctrl[1]) ? 1'b0 : m_run;
      n_tmo   = ex ? 1'b1 : ws ? 1'b0 : m_tmo;
      if (wc) m_ctrl = d;
      if (wp) m_per = d;
      m_cnt = n_cnt; m_run = n_run_v; m_tmo = n_tmo;
   endtask

   // one clock: drive at falling edge, check reads, then commit at rising edge
   task automatic step(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string tag = "");
      @(negedge clk);
      wr_en = we; addr = a; wdata = d;
      #1;
      check((tag == "") ? tag_of(a) : tag, rdata, m_read(a));
      check("R9", DW'(irq), DW'(m_tmo && m_ctrl[0]));
      @(posedge clk);
      model_edge(we, a, d);
   endtask

   function automatic logic [AW-1:0] wa(input int w);
      return AW'(w << 2);
   endfunction

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5e_ed01));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset state
      for (int w = 0; w < 4; w++) step(0, wa(w), '0, "R1");
      check("R1 irq", DW'(irq), '0);

      // R2: low address bits ignored for a control write/read
      step(1, AW'(5'b00111), 32'hA5A5_0000, "R2");
      step(0, AW'(5'b00110), '0, "R2");
      check("R2 ctrl", rdata, 32'hA5A5_0000);

      // R3 + R6: one-shot with period 3
      step(1, wa(2), 32'd3);
      step(0, wa(3), '0, "R3");
      check("R3 snapshot", rdata, 32'd3);
      step(1, wa(1), 32'h5);            // ien + go
      for (int i = 0; i < 5; i++) step(0, wa(3), '0, "R5");
      step(0, wa(0), '0, "R6");
      check("R6 status", rdata, 32'h1);
      check("R9 irq high", DW'(irq), 32'd1);

      // R8: clear with arbitrary data
      step(1, wa(0), 32'hFFFF_FFFF, "R8");
      step(0, wa(0), '0, "R8");
      check("R8 cleared", rdata, 32'h0);

      // R7: continuous reload, period 2
      step(1, wa(2), 32'd2);
      step(1, wa(1), 32'h6);
      for (int i = 0; i < 8; i++) step(0, wa(3), '0, "R7");
      step(0, wa(0), '0, "R7");
      check("R7 still running", DW'(rdata[1]), 32'd1);

      // R8: status write landing on an expiry edge (count at 1) keeps flag set
      step(1, wa(2), 32'd1);
      step(1, wa(0), '0, "R8");
      step(0, wa(0), '0, "R8");
      check("R8 expiry wins", DW'(rdata[0]), 32'd1);

      // R4: start and stop together -> stopped
      step(1, wa(1), 32'hC);
      step(0, wa(0), '0, "R4");
      check("R4 halt wins", DW'(rdata[1]), 32'd0);

      // R10: snapshot and unmapped writes ignored, unmapped reads zero
      step(1, wa(2), 32'd9);
      step(1, wa(3), 32'd77, "R10");
      step(1, wa(6), 32'hDEAD_BEEF, "R10");
      step(0, wa(3), '0, "R10");
      check("R10 snapshot kept", rdata, 32'd9);
      step(0, wa(5), '0, "R10");
      check("R10 unmapped", rdata, '0);

      // random mix
      for (int k = 0; k < 3000; k++) begin
         int w;
         logic we;
         logic [DW-1:0] d;
         w  = ($urandom % 10 < 8) ? int'($urandom % 4) : int'(4 + $urandom % 4);
         we = ($urandom % 3) == 0;
         case (w)
            1:       d = DW'($urandom % 16);
            2:       d = DW'($urandom % 12);
            default: d = $urandom;
         endcase
         step(we, AW'((w << 2) | int'($urandom % 4)), d);
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule